// File: doc/BRIEF.md
# Real-Time Clock Register Port with Interrupt Flags

This block is the register front end of a real-time clock. A host reaches a 128-byte space through two addresses: a write to the even address selects a byte by latching a 7-bit pointer, and an access to the odd address reads or writes the selected byte. Four bytes in that space are control registers with special rules. The other bytes are plain storage.

Counting time is not part of this block. Periodic, alarm and update-ended events arrive as single-cycle input pulses. Each event sets a flag in the status register. A flag that is newly set and enabled raises the master flag and the interrupt output. Reading the status register returns its value and then clears it, which also drops the interrupt. If a source is enabled while its flag is already pending, the interrupt is raised at once.

Top module: `rtc_index_port`

## Requirements
- R1: A write with `busSel`=0 stores `wrData[6:0]` as the pointer, and bit 7 is ignored. A read with `busSel`=0 returns 0xFF.
- R2: Any pointer value other than 0x0A to 0x0D addresses a storage byte, and a read returns the last value written to that byte.
- R3: After `rst_n` is asserted, control A (0x0A) reads 0x26, control B (0x0B) reads 0x02, status (0x0C) reads 0x00, fixed register (0x0D) reads 0x80, and `irq` is low.
- R4: The status register (0x0C) and the fixed register (0x0D) ignore writes. The fixed register always reads 0x80.
- R5: A read of the status register returns its value in the same cycle. From the next edge the register is 0x00 and `irq` is low.
- R6: An event pulse sets its status flag: periodic sets bit 6, alarm sets bit 5, update-ended sets bit 4. Status bits 3:0 always read 0.
- R7: If an event sets a flag that was clear before and the matching enable in control B is set, status bit 7 (the master flag) is set and `irq` rises after the next edge. The enables are B bit 6 for periodic, B bit 5 for alarm and B bit 4 for update-ended. An event whose flag is already set, or whose enable is clear, leaves bit 7 and `irq` unchanged.
- R8: A write to control B stores the byte. If any enabled source in the new value has its flag pending, bit 7 and `irq` are set. Otherwise they are cleared. The flags in bits 6:4 are unchanged by the write.
- R9: Bit 7 of control A is the update-in-progress bit. It is read-only, and a write to A keeps its old value there. Bits 6:0 take the written data.
- R10: A `softRst` pulse clears B bits 6, 5 and 3 and keeps the other bits of B. It also clears the status register and lowers `irq`.
- R11: An event that arrives in the same cycle as a status read is not lost. The read returns the old value, and afterwards the status holds the new flag. The master flag is set if that source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Address bit: 0 selects the pointer, 1 selects data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| softRst | input | 1 | Clears interrupt enables and flags |
| evtPeriodic | input | 1 | Periodic event pulse |
| evtAlarm | input | 1 | Alarm event pulse |
| evtUpdate | input | 1 | Update-ended event pulse |
| rdData | output | 8 | Read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt request |

## Verification
Read data comes straight from the registers in the cycle of the read. The bench drives a read after a falling edge and samples `rdData` 1 ns later, before the next rising edge. Writes, event pulses, status clears and `softRst` take effect at the next rising edge, and `irq` is a register output. The bench therefore samples `irq` at the falling edge that follows, one cycle after the stimulus. For a coincident event and status read, the returned value is checked in the read cycle and the new flag is checked with a second read.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int DATA_W = 8;

  // Pointer values with special meaning (address decode depends on these)
  localparam logic [6:0] IDX_CTL_A  = 7'h0A;
  localparam logic [6:0] IDX_CTL_B  = 7'h0B;
  localparam logic [6:0] IDX_STATUS = 7'h0C;
  localparam logic [6:0] IDX_FIXED  = 7'h0D;

  localparam logic [DATA_W-1:0] RST_CTL_A  = 8'h26;
  localparam logic [DATA_W-1:0] RST_CTL_B  = 8'h02;
  localparam logic [DATA_W-1:0] FIXED_VAL  = 8'h80;
  localparam logic [DATA_W-1:0] IDLE_READ  = 8'hFF;

  // Bit positions
  localparam int MASTER_BIT = 7;
  localparam int SRC_HI     = 6;  // periodic
  localparam int SRC_LO     = 4;  // update-ended
  localparam int SQW_BIT    = 3;
  localparam int UIP_BIT    = 7;

  typedef enum logic [2:0] {SEL_MEM, SEL_A, SEL_B, SEL_STAT, SEL_FIXED} regSel_e;

  typedef struct packed {
    logic    idxWr;
    logic    idxRd;
    logic    dataWr;
    logic    dataRd;
    logic    softClr;
    regSel_e sel;
  } portStrobe_t;
endpackage

// File: rtl/rtc_port_ctrl.sv
module rtc_port_ctrl
  import rtc_port_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             busSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             softRst,
  input  logic [IDX_W-1:0] curIdx,
  output portStrobe_t      strb
);
  always_comb begin
    strb         = '0;
    strb.idxWr   = wrEn & ~busSel;
    strb.idxRd   = rdEn & ~busSel;
    strb.dataWr  = wrEn & busSel;
    strb.dataRd  = rdEn & busSel;
    strb.softClr = softRst;
    if (curIdx == IDX_W'(IDX_CTL_A))       strb.sel = SEL_A;
    else if (curIdx == IDX_W'(IDX_CTL_B))  strb.sel = SEL_B;
    else if (curIdx == IDX_W'(IDX_STATUS)) strb.sel = SEL_STAT;
    else if (curIdx == IDX_W'(IDX_FIXED))  strb.sel = SEL_FIXED;
    else                                   strb.sel = SEL_MEM;
  end
endmodule

// File: rtl/rtc_port_dp.sv
module rtc_port_dp
  import rtc_port_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  portStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        evtBits,   // {periodic, alarm, update}
  output logic [IDX_W-1:0]  curIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int SRC_N = SRC_HI - SRC_LO + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ctlA, ctlB, stat;
  logic [DATA_W-1:0] ctlANext, ctlBNext, statNext;
  logic [SRC_N-1:0]  freshSrc;

  always_comb begin
    ctlANext = ctlA;
    ctlBNext = ctlB;
    statNext = stat;
    if (strb.dataWr && strb.sel == SEL_A)
      ctlANext = {ctlA[UIP_BIT], wrData[UIP_BIT-1:0]};
    if (strb.dataWr && strb.sel == SEL_B) begin
      ctlBNext = wrData;
      statNext[MASTER_BIT] = |(wrData[SRC_HI:SRC_LO] & stat[SRC_HI:SRC_LO]);
    end
    if (strb.dataRd && strb.sel == SEL_STAT)
      statNext = '0;
    if (strb.softClr) begin
      ctlBNext[SRC_HI]     = 1'b0;
      ctlBNext[SRC_HI-1]   = 1'b0;
      ctlBNext[SQW_BIT]    = 1'b0;
      statNext             = '0;
    end
    freshSrc = evtBits & ~statNext[SRC_HI:SRC_LO];
    statNext[SRC_HI:SRC_LO] = statNext[SRC_HI:SRC_LO] | evtBits;
    if (|(freshSrc & ctlBNext[SRC_HI:SRC_LO]))
      statNext[MASTER_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curIdx <= '0;
      ctlA   <= RST_CTL_A;
      ctlB   <= RST_CTL_B;
      stat   <= '0;
    end else begin
      if (strb.idxWr) curIdx <= wrData[IDX_W-1:0];
      ctlA <= ctlANext;
      ctlB <= ctlBNext;
      stat <= statNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.dataWr && strb.sel == SEL_MEM) mem[curIdx] <= wrData;
  end

  always_comb begin
    rdData = '0;
    if (strb.dataRd) begin
      case (strb.sel)
        SEL_A:     rdData = ctlA;
        SEL_B:     rdData = ctlB;
        SEL_STAT:  rdData = stat;
        SEL_FIXED: rdData = FIXED_VAL;
        default:   rdData = mem[curIdx];
      endcase
    end else if (strb.idxRd) begin
      rdData = IDLE_READ;
    end
  end

  assign irq = stat[MASTER_BIT];
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_port_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  input  logic       softRst,
  input  logic       evtPeriodic,
  input  logic       evtAlarm,
  input  logic       evtUpdate,
  output logic [7:0] rdData,
  output logic       irq
);
  portStrobe_t      strb;
  logic [IDX_W-1:0] curIdx;

  rtc_port_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .busSel(busSel), .wrEn(wrEn), .rdEn(rdEn), .softRst(softRst),
    .curIdx(curIdx), .strb(strb)
  );

  rtc_port_dp #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .evtBits({evtPeriodic, evtAlarm, evtUpdate}),
    .curIdx(curIdx), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/rtc_index_port_chk.sv
module rtc_index_port_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busSel,
  input logic             wrEn,
  input logic             rdEn,
  input logic [2:0]       enBits,
  input logic             softRst,
  input logic [2:0]       evts,
  input logic [7:0]       rdData,
  input logic             irq,
  input logic [IDX_W-1:0] curIdx
);
  logic bWr, statRd, fixedRd, aRd;
  assign bWr     = wrEn && busSel && curIdx == IDX_W'(7'h0B);
  assign statRd  = rdEn && busSel && curIdx == IDX_W'(7'h0C);
  assign fixedRd = rdEn && busSel && curIdx == IDX_W'(7'h0D);
  assign aRd     = rdEn && busSel && curIdx == IDX_W'(7'h0A);

  a_r1_even_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !busSel) |-> rdData == 8'hFF);
  a_r4_fixed_value: assert property (@(posedge clk) disable iff (!rst_n)
    fixedRd |-> rdData == 8'h80);
  a_r5_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (statRd && evts == 3'b000) |=> !irq);
  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evts != 3'b000 || bWr));
  a_r8_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bWr && enBits == 3'b000) |=> !irq);
  a_r9_uip_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    aRd |-> !rdData[7]);
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> !irq);
endmodule

bind rtc_index_port rtc_index_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busSel(busSel), .wrEn(wrEn), .rdEn(rdEn),
  .enBits(wrData[6:4]), .softRst(softRst),
  .evts({evtPeriodic, evtAlarm, evtUpdate}),
  .rdData(rdData), .irq(irq), .curIdx(curIdx)
);

// File: tb/rtc_index_port_bench.sv
`timescale 1ns/1ps
module rtc_index_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0, softRst = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic evtPeriodic = 1'b0, evtAlarm = 1'b0, evtUpdate = 1'b0;
  logic [7:0] rdData;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_index_port u_rtc_index_port (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .softRst(softRst), .evtPeriodic(evtPeriodic),
    .evtAlarm(evtAlarm), .evtUpdate(evtUpdate), .rdData(rdData), .irq(irq)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic checkIrq(string req, logic exp);
    check8(req, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic busWrite(logic sel, logic [7:0] d);
    @(negedge clk);
    busSel = sel; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regWrite(logic [7:0] idx, logic [7:0] d);
    busWrite(1'b0, idx);
    busWrite(1'b1, d);
  endtask

  // read through the currently latched pointer, with optional coincident events
  task automatic busRead(logic sel, logic [2:0] ev, string req, logic [7:0] exp);
    @(negedge clk);
    busSel = sel; rdEn = 1'b1;
    {evtPeriodic, evtAlarm, evtUpdate} = ev;
    #1 check8(req, rdData, exp);
    @(negedge clk);
    rdEn = 1'b0;
    {evtPeriodic, evtAlarm, evtUpdate} = 3'b000;
  endtask

  task automatic regRead(logic [7:0] idx, string req, logic [7:0] exp);
    busWrite(1'b0, idx);
    busRead(1'b1, 3'b000, req, exp);
  endtask

  task automatic pulse(logic [2:0] ev);
    @(negedge clk);
    {evtPeriodic, evtAlarm, evtUpdate} = ev;
    @(negedge clk);
    {evtPeriodic, evtAlarm, evtUpdate} = 3'b000;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    checkIrq("R3 irq", 1'b0);
    regRead(8'h0A, "R3 A", 8'h26);
    regRead(8'h0B, "R3 B", 8'h02);
    regRead(8'h0C, "R3 C", 8'h00);
    regRead(8'h0D, "R3 D", 8'h80);

    // R1 even read
    busRead(1'b0, 3'b000, "R1 even read", 8'hFF);

    // R2 storage sweep, pointer written with bit 7 set (R1 masking)
    for (int i = 0; i < 128; i++) begin
      if (i < 10 || i > 13) regWrite(8'(i) | 8'h80, 8'(i) ^ 8'h5A);
    end
    for (int i = 0; i < 128; i++) begin
      if (i < 10 || i > 13) regRead(8'(i), "R2 R1 byte", 8'(i) ^ 8'h5A);
    end

    // R9 UIP preserved
    regWrite(8'h0A, 8'hFF);
    regRead(8'h0A, "R9 A", 8'h7F);
    regWrite(8'h0A, 8'h80);
    regRead(8'h0A, "R9 A", 8'h00);
    regWrite(8'h0A, 8'h26);

    // R6 R7 exhaustive event x enable
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 8; ev++) begin
        regWrite(8'h0B, 8'(en << 4) | 8'h02);
        busWrite(1'b0, 8'h0C);
        busRead(1'b1, 3'b000, "R5 prep", 8'h00);
        pulse(3'(ev));
        checkIrq("R7 irq", |(3'(ev) & 3'(en)));
        busRead(1'b1, 3'b000, "R6 R7 status",
                {|(3'(ev) & 3'(en)), 3'(ev), 4'b0000});
        checkIrq("R5 irq low", 1'b0);
        busRead(1'b1, 3'b000, "R5 cleared", 8'h00);
      end
    end

    // R8 pending then enabled
    for (int p = 0; p < 8; p++) begin
      for (int en = 0; en < 8; en++) begin
        regWrite(8'h0B, 8'h02);
        busWrite(1'b0, 8'h0C);
        busRead(1'b1, 3'b000, "R5 prep", 8'h00);
        pulse(3'(p));
        checkIrq("R7 disabled", 1'b0);
        regWrite(8'h0B, 8'(en << 4) | 8'h02);
        checkIrq("R8 enable pending", |(3'(p) & 3'(en)));
        regWrite(8'h0B, 8'h02);
        checkIrq("R8 clear", 1'b0);
        regRead(8'h0C, "R8 flags kept", {1'b0, 3'(p), 4'b0000});
      end
    end

    // R7 already-set flag does not re-raise
    regWrite(8'h0B, 8'h02);
    pulse(3'b010);
    regWrite(8'h0B, 8'h22);
    checkIrq("R8 raise", 1'b1);
    regWrite(8'h0B, 8'h02);
    regWrite(8'h0B, 8'h02);
    checkIrq("R8 lowered", 1'b0);
    // enable alarm without flag-new condition: must write B with enable -> raises (pending)
    // so instead keep master low via writing enable for a different source
    regWrite(8'h0B, 8'h42);
    pulse(3'b010);
    checkIrq("R7 stale flag", 1'b0);

    // R4 read-only registers
    regWrite(8'h0C, 8'hFF);
    regRead(8'h0C, "R4 C write ignored", 8'h20);
    regWrite(8'h0D, 8'h00);
    regRead(8'h0D, "R4 D", 8'h80);

    // R11 event coincident with status read
    regWrite(8'h0B, 8'h12);
    pulse(3'b100);
    busWrite(1'b0, 8'h0C);
    busRead(1'b1, 3'b001, "R11 old value", 8'h40);
    checkIrq("R11 irq", 1'b1);
    busRead(1'b1, 3'b000, "R11 kept", 8'h90);

    // R10 soft reset
    regWrite(8'h0B, 8'h7A);
    pulse(3'b100);
    checkIrq("R10 pre", 1'b1);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    checkIrq("R10 irq", 1'b0);
    regRead(8'h0B, "R10 B", 8'h12);
    regRead(8'h0C, "R10 C", 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule